// File: doc/BRIEF.md
# Unaligned Vector Load Realigner

This block fetches 16-byte vectors that may begin at any byte address, using a memory that can only return whole 16-byte words at addresses that are multiples of 16. It fetches the aligned word that holds the first wanted byte and then the word after it. It merges the two words with a byte-select pattern that depends only on the misalignment, which is the address modulo 16. Each result appears on the output with a one-cycle valid strobe.

A job starts with a start pulse that carries a base byte address, a byte stride and a vector count. When the stride equals the word size, the vectors lie back to back. In that case the block computes the select pattern once and reuses each fetched word as the lower half of the next vector, so it needs one fresh read per vector. For any other stride it fetches both words for every vector and recomputes the pattern from that vector's own address. The memory answers one cycle after each read request.

Top module: `vec_realign`

## Requirements
- R1: Every read the block issues has the low four bits of `mem_rd_addr` equal to zero.
- R2: For each vector, the block reads the word at the vector address with its low four bits cleared, and in the next cycle it reads the word 16 bytes above that.
- R3: Output byte i, at bits [8i+7:8i], equals byte (offset + i) of the 32-byte concatenation of the lower word (bytes 0 to 15) and the upper word (bytes 16 to 31). Here offset is the address modulo 16, and byte j of a memory word is the byte at word address + j, placed at bits [8j+7:8j].
- R4: With offset 0 the result equals the lower word exactly, and the contents of the upper word have no effect on it.
- R5: When the stride is 16, a job of N vectors issues exactly N+1 reads, one per cycle and with no gap, at consecutive aligned addresses. Its N results appear on N consecutive cycles.
- R6: When the stride is any value other than 16, a job of N vectors issues exactly 2N reads. Vector k is taken from address base + k·stride, using its own offset, and the results appear every second cycle.
- R7: `busy` rises in the cycle after an accepted start and falls when the last vector is presented. `done` is a one-cycle pulse in the same cycle as the last `out_valid`. A start while `busy` is high is ignored.
- R8: A job of N vectors produces exactly N `out_valid` pulses. A job with count 0 issues no reads and no `out_valid`, and it pulses `done` in the cycle after the start.
- R9: The first result of a job appears three clock edges after the edge that accepts the start.
- R10: After reset, `busy`, `done`, `out_valid` and `mem_rd_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a job when idle |
| base_addr | input | ADDR_W | Byte address of the first vector |
| stride | input | ADDR_W | Byte distance between vector starts |
| vec_count | input | CNT_W | Number of vectors in the job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_rd_en | output | 1 | Read request to the memory |
| mem_rd_addr | output | ADDR_W | Aligned word address of the read |
| mem_rd_data | input | 128 | Read word, valid one cycle after the request |
| out_valid | output | 1 | Result vector valid strobe |
| out_data | output | 128 | Realigned result vector |

## Verification
The assertions check on every cycle that reads are aligned and that each upper-word read follows its lower-word read by 16 bytes. They also check that stream reads advance one word per cycle, that `done` coincides with a final valid strobe, and that no extra result is emitted. The byte-exact contents of each result, for offsets 0, 5, 9 and 15 and for strides that change the offset from vector to vector, can only be shown by the bench's scenarios. The same holds for the absence of any effect from the upper word at offset 0, the read totals, the latency and the ignored mid-job start.

// File: rtl/vra_pkg.sv
// Shared constants and types for the vector realigner.
// Assumes a fixed 16-byte memory word and vector.
package vra_pkg;
    localparam int VB    = 16;
    localparam int OFF_W = $clog2(VB);
    localparam int VEC_W = 8 * VB;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [OFF_W-1:0] off_t;

    // Attributes of a read that are carried to the cycle its data returns
    typedef struct packed {
        logic vld;   // a read was issued
        logic keep;  // returned word becomes the lower word
        logic emit;  // returned word is the upper word of a result
        off_t off;   // misalignment used for this result
    } tag_t;
endpackage

// File: rtl/vra_sel_gen.sv
// Builds the per-lane byte-select pattern from the misalignment.
// Lane i selects byte off+i of the 32-byte pair. Purely combinational.
module vra_sel_gen
    import vra_pkg::*;
(
    input  off_t                   off,
    output logic [VB-1:0][OFF_W:0] sel
);
    for (genvar g = 0; g < VB; g++) begin : g_lane
        // shift-left pattern: lane index plus offset
        assign sel[g] = {1'b0, off} + (OFF_W + 1)'(g);
    end
endmodule

// File: rtl/vra_lane_mux.sv
// Byte permute: each result lane picks one byte of {hi_w, lo_w}.
// Assumes select values below 2*VB. Purely combinational.
module vra_lane_mux
    import vra_pkg::*;
(
    input  vec_t                   lo_w,
    input  vec_t                   hi_w,
    input  logic [VB-1:0][OFF_W:0] sel,
    output vec_t                   res
);
    logic [2*VEC_W-1:0] pair;
    assign pair = {hi_w, lo_w};

    for (genvar g = 0; g < VB; g++) begin : g_lane
        // select one byte of the concatenated pair
        assign res[8*g +: 8] = pair[8*sel[g] +: 8];
    end
endmodule

// File: rtl/vra_seq.sv
// Job sequencer: accepts a job, generates aligned read addresses and
// tags every read with its role (lower word, upper word, offset).
// Assumes a memory with one cycle of read latency and no back-pressure.
module vra_seq
    import vra_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  vec_count,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output tag_t              tag_q
);
    typedef enum logic {S_IDLE, S_RUN} st_t;

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(VB);

    st_t               st_q;
    logic [CNT_W:0]    issue_left_q;
    logic [CNT_W-1:0]  out_left_q;
    logic              unit_q, first_q, phase_q;
    logic [ADDR_W-1:0] vec_addr_q, stride_q, rd_ptr_q;
    off_t              off_q;
    logic              done_q;
    logic [ADDR_W-1:0] lo_cur;
    logic              keep_c, emit_c, emit_now;

    // aligned word holding the current general-mode vector start
    assign lo_cur   = {vec_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign rd_en    = (st_q == S_RUN) && (issue_left_q != '0);
    assign rd_addr  = unit_q ? rd_ptr_q : (phase_q ? lo_cur + WORD_STEP : lo_cur);
    assign keep_c   = unit_q | ~phase_q;
    assign emit_c   = unit_q ? ~first_q : phase_q;
    assign emit_now = tag_q.vld && tag_q.emit;
    assign busy     = (st_q == S_RUN);
    assign done     = done_q;

    // job state, address walk and read tagging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= S_IDLE;
            issue_left_q <= '0;
            out_left_q   <= '0;
            unit_q       <= 1'b0;
            first_q      <= 1'b0;
            phase_q      <= 1'b0;
            vec_addr_q   <= '0;
            stride_q     <= '0;
            rd_ptr_q     <= '0;
            off_q        <= '0;
            done_q       <= 1'b0;
            tag_q        <= '0;
        end else begin
            done_q    <= 1'b0;
            tag_q.vld  <= rd_en;
            tag_q.keep <= keep_c;
            tag_q.emit <= emit_c;
            tag_q.off  <= unit_q ? off_q : vec_addr_q[OFF_W-1:0];
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        if (vec_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q       <= S_RUN;
                            unit_q     <= (stride == WORD_STEP);
                            issue_left_q <= (stride == WORD_STEP)
                                          ? (CNT_W + 1)'(vec_count) + 1'b1
                                          : {vec_count, 1'b0};
                            out_left_q <= vec_count;
                            first_q    <= 1'b1;
                            phase_q    <= 1'b0;
                            vec_addr_q <= base_addr;
                            stride_q   <= stride;
                            rd_ptr_q   <= {base_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                            off_q      <= base_addr[OFF_W-1:0];
                        end
                    end
                end
                S_RUN: begin
                    if (rd_en) begin
                        issue_left_q <= issue_left_q - 1'b1;
                        first_q      <= 1'b0;
                        if (unit_q) begin
                            rd_ptr_q <= rd_ptr_q + WORD_STEP;
                        end else begin
                            phase_q <= ~phase_q;
                            if (phase_q) vec_addr_q <= vec_addr_q + stride_q;
                        end
                    end
                    if (emit_now) begin
                        out_left_q <= out_left_q - 1'b1;
                        if (out_left_q == CNT_W'(1)) begin
                            st_q   <= S_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[OFF_W-1:0] == '0));

    p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !unit_q && phase_q) |-> (rd_addr == $past(rd_addr) + WORD_STEP));

    p_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unit_q && !first_q) |-> (rd_addr == $past(rd_addr) + WORD_STEP));

    p_no_extra_r8: assert property (@(posedge clk) disable iff (!rst_n)
        emit_now |-> (out_left_q != '0));
endmodule

// File: rtl/vec_realign.sv
// Top: realigned 16-byte vector loads from an aligned-word memory.
// Keeps the lower word of each pair and permutes it with the upper word
// when that returns. Assumes one-cycle memory read latency.
module vec_realign
    import vra_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  vec_count,
    output logic              busy,
    output logic              done,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [VEC_W-1:0]  mem_rd_data,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data
);
    tag_t                   tag;
    logic [VB-1:0][OFF_W:0] sel;
    vec_t                   lo_q, merged;

    vra_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .stride    (stride),
        .vec_count (vec_count),
        .busy      (busy),
        .done      (done),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .tag_q     (tag)
    );

    vra_sel_gen u_sel (
        .off (tag.off),
        .sel (sel)
    );

    vra_lane_mux u_mux (
        .lo_w (lo_q),
        .hi_w (mem_rd_data),
        .sel  (sel),
        .res  (merged)
    );

    // capture lower words and register merged results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= tag.vld && tag.emit;
            if (tag.vld && tag.emit) out_data <= merged;
            if (tag.vld && tag.keep) lo_q <= mem_rd_data;
        end
    end

    p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy == 1'b0 && $past(busy)) |-> out_valid);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en);
endmodule

// File: tb/vec_realign_test.sv
module vec_realign_test;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int MSZ = 4096;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [AW-1:0]  base_addr = '0;
    logic [AW-1:0]  stride = '0;
    logic [CW-1:0]  vec_count = '0;
    logic           busy, done, mem_rd_en, out_valid;
    logic [AW-1:0]  mem_rd_addr;
    logic [127:0]   mem_rd_data = '0;
    logic [127:0]   out_data;
    logic [7:0]     mem_b [0:MSZ-1];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vec_realign #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .stride(stride), .vec_count(vec_count), .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_data(out_data)
    );

    // memory model: one-cycle read, byte j of word at bits 8j
    always @(posedge clk) begin
        if (mem_rd_en)
            for (int j = 0; j < 16; j++)
                mem_rd_data[8*j +: 8] <= mem_b[(int'(mem_rd_addr) + j) % MSZ];
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    function automatic logic [127:0] exp_vec(input int addr);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = mem_b[(addr + i) % MSZ];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // run one job and check every result, its timing and the read total
    task automatic run_job(input int base, input int strd, input int cnt,
                           input string req, input bit poke_start,
                           output logic [127:0] first_out);
        int k = 0;
        int reads = 0;
        bit fin = 0;
        bit unit = (strd == 16);
        first_out = '0;
        @(negedge clk);
        start = 1'b1; base_addr = AW'(base); stride = AW'(strd); vec_count = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 1000 && !fin; c++) begin
            if (poke_start && c == 1) begin
                start = 1'b1; base_addr = AW'(16'h0700); stride = AW'(16); vec_count = CW'(3);
            end
            if (poke_start && c == 2) start = 1'b0;
            if (mem_rd_en) begin
                reads++;
                chk(mem_rd_addr[3:0] == 4'd0, "R1 aligned read", 128'(mem_rd_addr), 128'(mem_rd_addr & 16'hFFF0));
            end
            if (out_valid) begin
                if (k == 0) first_out = out_data;
                chk(out_data == exp_vec(base + k * strd), {req, " R3 vector data"}, out_data, exp_vec(base + k * strd));
                chk(c == (unit ? 3 + k : 3 + 2 * k), {req, " R9 timing"}, 128'(c), 128'(unit ? 3 + k : 3 + 2 * k));
                k++;
            end
            if (done) begin
                chk(out_valid && !busy, "R7 done with last valid, busy low", {126'd0, out_valid, busy}, 128'd2);
                fin = 1;
            end
            @(negedge clk);
        end
        chk(k == cnt, "R8 result count", 128'(k), 128'(cnt));
        chk(reads == (unit ? cnt + 1 : 2 * cnt), unit ? "R5 read total" : "R6 read total",
            128'(reads), 128'(unit ? cnt + 1 : 2 * cnt));
        chk(!busy && !done, "R7 idle after job", {126'd0, busy, done}, 128'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !out_valid && !mem_rd_en, "R10 reset state",
            {124'd0, busy, done, out_valid, mem_rd_en}, 128'd0);
    endtask

    task automatic t_stream();
        logic [127:0] f;
        run_job(32'h200, 16, 6, "R5 stream off0", 0, f);
        run_job(32'h205, 16, 6, "R5 stream off5", 0, f);
        run_job(32'h30F, 16, 5, "R5 stream off15", 0, f);
    endtask

    task automatic t_general();
        logic [127:0] f;
        run_job(32'h403, 48, 4, "R6 stride48", 0, f);
        run_job(32'h501, 23, 5, "R6 stride23 varying offset", 0, f);
        run_job(32'h609, 32, 3, "R6 stride32 R2", 0, f);
        run_job(32'h0A0, 7, 4, "R6 stride7", 0, f);
    endtask

    task automatic t_offset0();
        logic [127:0] a, b, w;
        w = exp_vec(32'h800);
        run_job(32'h800, 64, 1, "R4 offset0 first", 0, a);
        for (int i = 16'h810; i < 16'h820; i++) mem_b[i] = ~mem_b[i];
        run_job(32'h800, 64, 1, "R4 offset0 second", 0, b);
        chk(a == w, "R4 equals lower word", a, w);
        chk(b == a, "R4 upper word has no effect", b, a);
    endtask

    task automatic t_zero();
        int reads = 0;
        bit seen_v = 0;
        @(negedge clk);
        start = 1'b1; base_addr = 16'h0123; stride = 16'd16; vec_count = '0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R8 count0 done next cycle", 128'(done), 128'd1);
        chk(!busy, "R8 count0 not busy", 128'(busy), 128'd0);
        for (int c = 0; c < 5; c++) begin
            if (mem_rd_en) reads++;
            if (out_valid) seen_v = 1;
            @(negedge clk);
        end
        chk(reads == 0 && !seen_v, "R8 count0 no reads or results", 128'(reads), 128'd0);
    endtask

    task automatic t_start_busy();
        logic [127:0] f;
        run_job(32'h90C, 16, 4, "R7 start while busy ignored", 1, f);
    endtask

    initial begin
        for (int a = 0; a < MSZ; a++) mem_b[a] = 8'((a * 37) + (a >> 4) * 11 + 5);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_general();
        t_offset0();
        t_zero();
        t_start_busy();
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule